// File: doc/BRIEF.md
# Bidirectional Memory-Mapped GPIO Port

The block is an eight-pin general-purpose I/O port with three registers on a simple bus. The first register sets the direction of each pin and can only be written. The second holds output data and can be read and written. The third is read-only and returns the pin levels after synchronization. Each pin whose direction bit is set drives its data bit. Every other pin floats and acts as an input. The pad cell is outside the block. It receives a separate output-enable bit and output-value bit for each pin, and returns an input level for each pin.

The block treats four reset and low-power conditions in two different ways. A power-on reset, and hardware standby, clear both the direction and data registers. While hardware standby is asserted, every pad is also held at high impedance. A manual reset, and software standby, leave both registers unchanged. Bus writes are ignored while either of them is active, so the pins go on behaving exactly as the two registers dictate.

Top module: `gpio_port_top`

## Requirements
- R1: After power-on reset (`por_n` low), `pin_oe` is 0x00, `pin_out` is 0x00, and a read of the data register at 0xFF06 returns 0x00.
- R2: When direction bit i (address 0xFE36, bit i = pin i, 1 = output) is 1, `pin_oe[i]` is 1 and `pin_out[i]` equals data bit i. When direction bit i is 0, `pin_oe[i]` is 0. A write takes effect on the clock edge that samples it.
- R3: A read of the direction address 0xFE36 returns 0xFF, whatever the register holds.
- R4: The data register at 0xFF06 can be written and reads back the value written. Read data is combinational from `bus_addr` and `bus_rd`.
- R5: A read of 0xFFB6 returns `pin_in` as sampled two clock edges earlier. A write to 0xFFB6 changes no register.
- R6: While `mrst_n` is low, the direction and data registers keep their contents and bus writes are ignored.
- R7: While `sw_stby` is high, the direction and data registers keep their contents, bus writes are ignored, and the pins keep driving.
- R8: While `hw_stby` is high, `pin_oe` is 0x00 in the same cycle. Both registers are cleared at the next edge and bus writes are ignored. After standby is released, both registers read 0x00 and `pin_oe` stays 0x00.
- R9: The 16-bit address is decoded in full. A read of any other address returns 0x00, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, active low; registers retained |
| sw_stby | input | 1 | Software standby; registers retained |
| hw_stby | input | 1 | Hardware standby; pins float, registers cleared |
| bus_addr | input | 16 | Register address (low 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Output enable for each pin |
| pin_out | output | 8 | Output value for each pin |

## Verification
If a direction bit is wrong, the fault shows up on `pin_oe` right away in the same cycle. It cannot be seen on the bus, because the direction register always reads 0xFF. For that reason every direction check looks at the pins. If a write gate fails during manual reset or either standby mode, one of the registers is corrupted. That fault is visible on `pin_out` and `pin_oe`, and in the data readback, one edge after the ignored write. If the synchronizer depth is wrong, the pin-state readback shifts by one edge. This is seen by sampling after the first edge and again after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned PORT_W_DEF = 8;
   localparam int unsigned ADDR_W_DEF = 16;
   localparam int unsigned SYNC_N_DEF = 2;

   localparam logic [15:0] DIR_ADDR_DEF  = 16'hFE36;
   localparam logic [15:0] DATA_ADDR_DEF = 16'hFF06;
   localparam logic [15:0] PIN_ADDR_DEF  = 16'hFFB6;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_DATA = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned CNT_W = $clog2(STAGES + 1);

   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("gpio_port_sync: STAGES must be 2..4");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               chain[s] <= '0;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

   // Checker: once the input has held its value for STAGES edges, q shows it
   logic [WIDTH-1:0] prev_d;
   logic [CNT_W-1:0] hold_cnt;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prev_d   <= '0;
         hold_cnt <= '0;
      end else begin
         prev_d <= d;
         if (d != prev_d)                    hold_cnt <= '0;
         else if (hold_cnt < CNT_W'(STAGES)) hold_cnt <= hold_cnt + 1'b1;
      end
   end

   p_sync_settle_r5: assert property (@(posedge clk) disable iff (!por_n)
      (hold_cnt == CNT_W'(STAGES)) |-> (q == prev_d));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hw_stby,
   input  logic             wr_en,
   input  logic             sel_dir,
   input  logic             sel_data,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] data_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         dir_q <= '0;
      end else if (hw_stby) begin
         dir_q <= '0;
      end else if (wr_en && sel_dir) begin
         dir_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
      end else if (hw_stby) begin
         data_q <= '0;
      end else if (wr_en && sel_data) begin
         data_q <= wdata;
      end
   end

   p_stby_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |=> (dir_q == '0 && data_q == '0));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && sel_dir && !hw_stby) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             hw_stby,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out
);
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_pad
         assign pin_oe[i]  = dir_q[i] & ~hw_stby;
         assign pin_out[i] = data_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
   import gpio_port_pkg::*;
#(
   parameter int unsigned    PORT_W    = PORT_W_DEF,
   parameter int unsigned    ADDR_W    = ADDR_W_DEF,
   parameter int unsigned    SYNC_N    = SYNC_N_DEF,
   parameter logic [15:0]    DIR_ADDR  = DIR_ADDR_DEF,
   parameter logic [15:0]    DATA_ADDR = DATA_ADDR_DEF,
   parameter logic [15:0]    PIN_ADDR  = PIN_ADDR_DEF
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              sw_stby,
   input  logic              hw_stby,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out
);
   generate
      if (PORT_W < 1 || PORT_W > 32) begin : g_bad_width
         $error("gpio_port_top: PORT_W must be 1..32");
      end
      if (ADDR_W != 16) begin : g_bad_addr
         $error("gpio_port_top: ADDR_W must be 16");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_en;
   logic [PORT_W-1:0] dir_q, data_q, pin_sync;

   always_comb begin
      if      (bus_addr == DIR_ADDR)  sel = SEL_DIR;
      else if (bus_addr == DATA_ADDR) sel = SEL_DATA;
      else if (bus_addr == PIN_ADDR)  sel = SEL_PIN;
      else                            sel = SEL_NONE;
   end

   assign wr_en = bus_wr & mrst_n & ~sw_stby & ~hw_stby;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_DIR:  bus_rdata = '1;
            SEL_DATA: bus_rdata = data_q;
            SEL_PIN:  bus_rdata = pin_sync;
            default:  bus_rdata = '0;
         endcase
      end
   end

   gpio_port_regs #(.WIDTH(PORT_W)) regs_i (
      .clk      (clk),
      .por_n    (por_n),
      .hw_stby  (hw_stby),
      .wr_en    (wr_en),
      .sel_dir  (sel == SEL_DIR),
      .sel_data (sel == SEL_DATA),
      .wdata    (bus_wdata),
      .dir_q    (dir_q),
      .data_q   (data_q)
   );

   gpio_port_sync #(.WIDTH(PORT_W), .STAGES(SYNC_N)) sync_i (
      .clk   (clk),
      .por_n (por_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_port_pads #(.WIDTH(PORT_W)) pads_i (
      .hw_stby (hw_stby),
      .dir_q   (dir_q),
      .data_q  (data_q),
      .pin_oe  (pin_oe),
      .pin_out (pin_out)
   );

   p_stby_float_r8: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |-> (pin_oe == '0));

   p_hold_r6_r7: assert property (@(posedge clk) disable iff (!por_n)
      ((!mrst_n || sw_stby) && !hw_stby) |=> ($stable(pin_oe) && $stable(pin_out)));

   p_dir_read_r3: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_addr == DIR_ADDR) |-> (bus_rdata == '1));

   p_unmapped_r9: assert property (@(posedge clk) disable iff (!por_n)
      (bus_rd && bus_addr != DIR_ADDR && bus_addr != DATA_ADDR && bus_addr != PIN_ADDR)
      |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_top_tb_top.sv
module gpio_port_top_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b1;
   logic        sw_stby = 1'b0;
   logic        hw_stby = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_oe, pin_out;

   int n_checks = 0;
   int n_fail   = 0;

   localparam logic [15:0] A_DIR  = 16'hFE36;
   localparam logic [15:0] A_DATA = 16'hFF06;
   localparam logic [15:0] A_PIN  = 16'hFFB6;

   always #5 clk = ~clk;

   gpio_port_top dut_i (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .sw_stby(sw_stby),
      .hw_stby(hw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      check("R1 oe", pin_oe, 8'h00);
      check("R1 out", pin_out, 8'h00);
      bus_read(A_DATA, v);
      check("R1 data", v, 8'h00);
   endtask

   task automatic t_dir_data();
      logic [7:0] v;
      bus_write(A_DATA, 8'hA5);
      bus_read(A_DATA, v);
      check("R4 readback", v, 8'hA5);
      bus_write(A_DIR, 8'h0F);
      check("R2 oe", pin_oe, 8'h0F);
      check("R2 out", pin_out, 8'hA5);
      bus_write(A_DIR, 8'hF0);
      check("R2 oe swap", pin_oe, 8'hF0);
      bus_read(A_DIR, v);
      check("R3 dir read", v, 8'hFF);
      bus_write(A_DIR, 8'h00);
      bus_read(A_DIR, v);
      check("R3 dir read zero", v, 8'hFF);
      check("R2 oe clear", pin_oe, 8'h00);
      bus_write(A_DATA, 8'h3C);
      bus_read(A_DATA, v);
      check("R4 second", v, 8'h3C);
   endtask

   task automatic t_pin_state();
      logic [7:0] v;
      @(negedge clk);
      pin_in = 8'h11;
      repeat (3) @(negedge clk);
      pin_in = 8'h96;
      @(posedge clk);
      @(negedge clk);
      bus_addr = A_PIN; bus_rd = 1'b1;
      #1 check("R5 one edge", bus_rdata, 8'h11);
      @(posedge clk);
      #1 check("R5 two edges", bus_rdata, 8'h96);
      bus_rd = 1'b0;
      bus_write(A_PIN, 8'h00);
      bus_read(A_DATA, v);
      check("R5 pin write ignored data", v, 8'h3C);
      check("R5 pin write ignored oe", pin_oe, 8'h00);
   endtask

   task automatic t_manual();
      logic [7:0] v;
      bus_write(A_DIR, 8'hC3);
      @(negedge clk);
      mrst_n = 1'b0;
      bus_write(A_DATA, 8'h00);
      bus_write(A_DIR, 8'h00);
      check("R6 oe kept", pin_oe, 8'hC3);
      check("R6 out kept", pin_out, 8'h3C);
      @(negedge clk);
      mrst_n = 1'b1;
      bus_read(A_DATA, v);
      check("R6 data kept", v, 8'h3C);
   endtask

   task automatic t_sw_stby();
      logic [7:0] v;
      @(negedge clk);
      sw_stby = 1'b1;
      bus_write(A_DATA, 8'hFF);
      bus_write(A_DIR, 8'h01);
      check("R7 oe driving", pin_oe, 8'hC3);
      check("R7 out kept", pin_out, 8'h3C);
      @(negedge clk);
      sw_stby = 1'b0;
      bus_read(A_DATA, v);
      check("R7 data kept", v, 8'h3C);
   endtask

   task automatic t_hw_stby();
      logic [7:0] v;
      @(negedge clk);
      hw_stby = 1'b1;
      #1 check("R8 float same cycle", pin_oe, 8'h00);
      bus_write(A_DATA, 8'h77);
      bus_write(A_DIR, 8'hFF);
      check("R8 float held", pin_oe, 8'h00);
      @(negedge clk);
      hw_stby = 1'b0;
      #1 check("R8 oe after exit", pin_oe, 8'h00);
      check("R8 out cleared", pin_out, 8'h00);
      bus_read(A_DATA, v);
      check("R8 data cleared", v, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      bus_write(A_DATA, 8'h5A);
      bus_write(A_DIR, 8'h0F);
      bus_write(16'hFE37, 8'hFF);
      bus_write(16'h0F06, 8'h00);
      bus_read(16'h1234, v);
      check("R9 read unmapped", v, 8'h00);
      bus_read(16'hFF07, v);
      check("R9 read near", v, 8'h00);
      check("R9 oe unchanged", pin_oe, 8'h0F);
      bus_read(A_DATA, v);
      check("R9 data unchanged", v, 8'h5A);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      t_reset();
      t_dir_data();
      t_pin_state();
      t_manual();
      t_sw_stby();
      t_hw_stby();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule